// File: doc/BRIEF.md
# Byte-Wide Disk Bus Command Sequencer

This block is the host-side engine that carries one command across a byte-wide disk controller bus. After a start pulse it selects the controller and writes the transfer mode to the control port. It then waits for the controller to report itself selected. From then on the controller leads: each time it raises ready, the sequencer reads two status bits, `st_cmd` and `st_in`, to learn the bus phase. In that phase it sends the next byte of the six-byte command block, moves one data byte, or hands the data phase to a DMA channel. The last phase is the completion status byte. The sequencer then waits for the controller to release select.

When the status byte flags an error, the block does not report straight away. It runs a second, nested command on its own: a sense request aimed at the logical unit named in the status byte. It stores the four bytes that come back and then reports an error result, with the sense data alongside. Every bus wait has a timeout that the host programs. It counts afresh in each wait, and an expiry ends the command with a timeout result.

Host data moves over two valid/ready byte streams. The outgoing stream (`out_*`) is consumed only while the bus is in a data-to-controller phase. A byte is taken, and written to the bus in the same cycle, when `out_valid` and `out_ready` are both high. While `out_valid` is low the write is held back. The incoming stream (`in_*`) offers one byte per data-from-controller phase. The bus read strobe fires in the same cycle that `in_valid` and `in_ready` are both high. While `in_ready` is low the read is held back and `in_data` has no meaning. Stalls on either stream never count toward a timeout.

Top module: `xtb_cmd_seq`

## Requirements
- R1: A start pulse accepted while idle produces one cycle of `bus_sel_wr`. The next cycle writes the control port with the mode byte: 0x03 for DMA, 0x00 for byte-by-byte transfer. The sequencer then waits for `st_sel` to go high.
- R2: On each cycle with `st_rdy` high, the phase is decoded from {`st_cmd`,`st_in`}. 2'b10 writes the next command byte; byte 0 is `cmd_blk[7:0]`, in ascending order, and a seventh or later request gets 0x00. 2'b00 is data to the controller, 2'b01 is data from the controller, and 2'b11 ends the transfer loop.
- R3: In a data-to-controller phase the byte comes from the outgoing stream when `has_src` was high at start. Otherwise a 0x00 byte is written.
- R4: In a data-from-controller phase the byte is passed to the incoming stream when `has_dst` was high at start, and the read waits for `in_ready`. Otherwise the byte is read and discarded, and `in_valid` stays low.
- R5: After phase 2'b11 the sequencer reads one status byte, waits for `st_sel` to fall, then pulses `done` for one cycle. `result` is 0 when status bit 1 is clear.
- R6: A bus wait (select high, ready, interrupt, select low) ends the command when its condition stays false for `tmo_limit` cycles. `done` then pulses with `result` = 1, and no sense command follows.
- R7: When status bit 1 is set, a sense command runs in byte-by-byte mode. Its block is 0x03, {status[7:5],5'b0}, then four 0x00 bytes. Its first four data-from-controller bytes go to `sense_bytes`, with byte 0 in bits 7:0. `result` becomes 2.
- R8: In DMA mode a data phase raises `dma_en` and makes no data strobe until `st_irq` is high. The interrupt is then acknowledged by writing 0x00 to the control port, and the acknowledge happens only after `st_irq` has been seen high.
- R9: A start pulse while `busy` is high is ignored.
- R10: The timeout counter reloads on entry to every wait. A command whose individual waits each stay below `tmo_limit` cycles completes normally, however long it runs in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only while idle |
| cmd_blk | input | 48 | Six-byte command block, byte 0 in bits 7:0 |
| use_dma | input | 1 | Use DMA for data phases |
| has_src | input | 1 | Outgoing data comes from the out stream |
| has_dst | input | 1 | Incoming data goes to the in stream |
| tmo_limit | input | 16 | Wait timeout in cycles, at least 1 |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 timeout, 2 error with sense valid |
| sense_bytes | output | 32 | Captured sense bytes |
| out_valid | input | 1 | Outgoing byte available |
| out_ready | output | 1 | Outgoing byte taken |
| out_data | input | 8 | Outgoing byte |
| in_valid | output | 1 | Incoming byte offered |
| in_ready | input | 1 | Sink accepts incoming byte |
| in_data | output | 8 | Incoming byte |
| bus_sel_wr | output | 1 | Select port write strobe |
| bus_ctl_wr | output | 1 | Control port write strobe |
| bus_ctl_data | output | 8 | Control port write value |
| bus_data_wr | output | 1 | Data port write strobe |
| bus_data_rd | output | 1 | Data port read strobe |
| bus_wdata | output | 8 | Data port write value |
| bus_rdata | input | 8 | Data port read value |
| st_sel | input | 1 | Status: controller selected |
| st_rdy | input | 1 | Status: ready for next phase |
| st_cmd | input | 1 | Status: command phase bit |
| st_in | input | 1 | Status: input direction bit |
| st_irq | input | 1 | Status: interrupt pending |
| dma_en | output | 1 | DMA channel enable |

## Verification
The bench targets the exact timeout boundary. A ready gap one cycle under the limit must pass, while a gap at the limit must time out after exactly one command byte. An off-by-one counter would either hang or abort commands that are valid. The nested sense run is checked with a DMA-mode parent command. A design that reused the parent mode, misplaced the unit number or failed to reload the block would write the wrong control byte or the wrong sense block. The bench also covers a long stall on the incoming stream, which must neither time out nor drop the byte, and the zero-fill and discard cases. It checks that DMA phases make no data strobes and that a second start during a command changes nothing.

// File: rtl/xtb_pkg.sv
package xtb_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_SEL, S_MODE, S_WSEL, S_WRDY, S_CMDB, S_DOUT,
    S_DIN, S_DMAW, S_DACK, S_STAT, S_WDSEL, S_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    RES_OK  = 2'd0,
    RES_TMO = 2'd1,
    RES_ERR = 2'd2
  } seq_result_e;

  // {st_cmd, st_in} phase codes
  localparam logic [1:0] PH_DOUT = 2'b00;
  localparam logic [1:0] PH_DIN  = 2'b01;
  localparam logic [1:0] PH_CMD  = 2'b10;
  localparam logic [1:0] PH_END  = 2'b11;

  localparam logic [7:0] SENSE_OPCODE = 8'h03;
  localparam int         CSB_ERR_BIT  = 1;
  localparam int         CSB_LUN_LSB  = 5;
endpackage

// File: rtl/xtb_wait_timer.sv
module xtb_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          waiting,
  input  logic          cond,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;

  assign expired = waiting && !cond && (cnt == limit - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart)          cnt <= '0;
    else if (waiting && !cond) cnt <= cnt + TW'(1);
  end

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && limit != '0) |-> (cnt < limit));
endmodule

// File: rtl/xtb_cmd_block.sv
module xtb_cmd_block
  import xtb_pkg::*;
#(
  parameter int NB = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_host,
  input  logic [8*NB-1:0] host_blk,
  input  logic            load_sense,
  input  logic [2:0]      sense_lun,
  input  logic            advance,
  output logic [7:0]      cur_byte
);
  localparam int IW = $clog2(NB + 1);

  logic [7:0]    blk [NB];
  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NB; i++) begin
      if (load_host)
        blk[i] <= host_blk[8*i +: 8];
      else if (load_sense)
        blk[i] <= (i == 0) ? SENSE_OPCODE :
                  (i == 1) ? {sense_lun, 5'b0} : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              idx <= '0;
    else if (load_host || load_sense)        idx <= '0;
    else if (advance && idx != IW'(NB))      idx <= idx + IW'(1);
  end

  assign cur_byte = (idx < IW'(NB)) ? blk[idx] : 8'h00;

  // R2
  idx_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IW'(NB));
endmodule

// File: rtl/xtb_sense_cap.sv
module xtb_sense_cap #(
  parameter int NS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            capture,
  input  logic [7:0]      byte_in,
  output logic [8*NS-1:0] bytes
);
  localparam int CW = $clog2(NS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes <= '0;
      cnt   <= '0;
    end else if (clear) begin
      bytes <= '0;
      cnt   <= '0;
    end else if (capture && cnt != CW'(NS)) begin
      bytes[8*int'(cnt) +: 8] <= byte_in;
      cnt <= cnt + CW'(1);
    end
  end

  // R7
  sense_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(NS));
endmodule

// File: rtl/xtb_cmd_seq.sv
module xtb_cmd_seq
  import xtb_pkg::*;
#(
  parameter int         TW        = 16,
  parameter int         CMD_BYTES = 6,
  parameter int         SNS_BYTES = 4,
  parameter logic [7:0] DMA_MODE  = 8'h03,
  parameter logic [7:0] PIO_MODE  = 8'h00
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [8*CMD_BYTES-1:0] cmd_blk,
  input  logic                   use_dma,
  input  logic                   has_src,
  input  logic                   has_dst,
  input  logic [TW-1:0]          tmo_limit,
  output logic                   busy,
  output logic                   done,
  output logic [1:0]             result,
  output logic [8*SNS_BYTES-1:0] sense_bytes,
  input  logic                   out_valid,
  output logic                   out_ready,
  input  logic [7:0]             out_data,
  output logic                   in_valid,
  input  logic                   in_ready,
  output logic [7:0]             in_data,
  output logic                   bus_sel_wr,
  output logic                   bus_ctl_wr,
  output logic [7:0]             bus_ctl_data,
  output logic                   bus_data_wr,
  output logic                   bus_data_rd,
  output logic [7:0]             bus_wdata,
  input  logic [7:0]             bus_rdata,
  input  logic                   st_sel,
  input  logic                   st_rdy,
  input  logic                   st_cmd,
  input  logic                   st_in,
  input  logic                   st_irq,
  output logic                   dma_en
);
  seq_state_e  state, nxt;
  seq_result_e result_r, res_nxt;
  logic        dma_r, hout_r, hin_r, sense_pass;
  logic [7:0]  csb_r, cmd_byte;
  logic        waiting, cond, expired;
  logic        start_acc, load_sense, cmd_adv, sns_cap;
  logic        dma_eff, hout_eff, hin_eff;

  assign dma_eff  = dma_r  && !sense_pass;
  assign hout_eff = hout_r && !sense_pass;
  assign hin_eff  = hin_r  && !sense_pass;

  assign start_acc  = (state == S_IDLE) && start;
  assign load_sense = (state == S_WDSEL) && !st_sel &&
                      csb_r[CSB_ERR_BIT] && !sense_pass;

  // which condition each wait state watches
  always_comb begin
    waiting = 1'b1;
    cond    = 1'b1;
    case (state)
      S_WSEL:  cond = st_sel;
      S_WRDY:  cond = st_rdy;
      S_DMAW:  cond = st_irq;
      S_WDSEL: cond = !st_sel;
      default: waiting = 1'b0;
    endcase
  end

  always_comb begin
    nxt     = state;
    res_nxt = result_r;
    case (state)
      S_IDLE:  if (start) nxt = S_SEL;
      S_SEL:   nxt = S_MODE;
      S_MODE:  nxt = S_WSEL;
      S_WSEL:  if (st_sel) nxt = S_WRDY;
               else if (expired) begin nxt = S_DONE; res_nxt = RES_TMO; end
      S_WRDY:  if (st_rdy) begin
                 case ({st_cmd, st_in})
                   PH_CMD:  nxt = S_CMDB;
                   PH_DOUT: nxt = dma_eff ? S_DMAW : S_DOUT;
                   PH_DIN:  nxt = dma_eff ? S_DMAW : S_DIN;
                   default: nxt = S_STAT;
                 endcase
               end else if (expired) begin nxt = S_DONE; res_nxt = RES_TMO; end
      S_CMDB:  nxt = S_WRDY;
      S_DOUT:  if (!hout_eff || out_valid) nxt = S_WRDY;
      S_DIN:   if (!hin_eff || in_ready) nxt = S_WRDY;
      S_DMAW:  if (st_irq) nxt = S_DACK;
               else if (expired) begin nxt = S_DONE; res_nxt = RES_TMO; end
      S_DACK:  nxt = S_WRDY;
      S_STAT:  nxt = S_WDSEL;
      S_WDSEL: if (!st_sel) begin
                 if (load_sense) nxt = S_SEL;
                 else begin
                   nxt     = S_DONE;
                   res_nxt = sense_pass ? RES_ERR : RES_OK;
                 end
               end else if (expired) begin nxt = S_DONE; res_nxt = RES_TMO; end
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      result_r   <= RES_OK;
      dma_r      <= 1'b0;
      hout_r     <= 1'b0;
      hin_r      <= 1'b0;
      sense_pass <= 1'b0;
      csb_r      <= 8'h00;
    end else begin
      state    <= nxt;
      result_r <= res_nxt;
      if (start_acc) begin
        dma_r      <= use_dma;
        hout_r     <= has_src;
        hin_r      <= has_dst;
        sense_pass <= 1'b0;
      end
      if (load_sense) sense_pass <= 1'b1;
      if (state == S_STAT) csb_r <= bus_rdata;
    end
  end

  assign cmd_adv = (state == S_CMDB);
  assign sns_cap = (state == S_DIN) && sense_pass;

  xtb_wait_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(nxt != state), .waiting(waiting),
    .cond(cond), .limit(tmo_limit), .expired(expired)
  );

  xtb_cmd_block #(.NB(CMD_BYTES)) u_cmd (
    .clk(clk), .rst_n(rst_n), .load_host(start_acc), .host_blk(cmd_blk),
    .load_sense(load_sense), .sense_lun(csb_r[CSB_LUN_LSB +: 3]),
    .advance(cmd_adv), .cur_byte(cmd_byte)
  );

  xtb_sense_cap #(.NS(SNS_BYTES)) u_sense (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .capture(sns_cap),
    .byte_in(bus_rdata), .bytes(sense_bytes)
  );

  assign busy         = (state != S_IDLE);
  assign done         = (state == S_DONE);
  assign result       = result_r;
  assign bus_sel_wr   = (state == S_SEL);
  assign bus_ctl_wr   = (state == S_MODE) || (state == S_DACK);
  assign bus_ctl_data = (state == S_MODE) ? (dma_eff ? DMA_MODE : PIO_MODE) : 8'h00;
  assign bus_data_wr  = (state == S_CMDB) || ((state == S_DOUT) && (!hout_eff || out_valid));
  assign bus_data_rd  = (state == S_STAT) || ((state == S_DIN) && (!hin_eff || in_ready));
  assign bus_wdata    = (state == S_CMDB) ? cmd_byte : (hout_eff ? out_data : 8'h00);
  assign out_ready    = (state == S_DOUT) && hout_eff;
  assign in_valid     = (state == S_DIN) && hin_eff;
  assign in_data      = bus_rdata;
  assign dma_en       = (state == S_DMAW);

  // R1
  sel_then_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel_wr |=> bus_ctl_wr);
  // R8
  ack_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ctl_wr && !$past(bus_sel_wr)) |-> $past(st_irq));
  // R8
  dma_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_en |-> !(bus_data_wr || bus_data_rd));
  // R4
  in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> bus_data_rd);
  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_sel_wr, bus_ctl_wr, bus_data_wr, bus_data_rd}));
  // R9
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R6
  result_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result != 2'd3));
endmodule

// File: tb/test_xtb_cmd_seq.sv
module test_xtb_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [47:0] cmd_blk = '0;
  logic        use_dma = 1'b0, has_src = 1'b0, has_dst = 1'b0;
  logic [TW-1:0] tmo_limit = TW'(8);
  logic        busy, done;
  logic [1:0]  result;
  logic [31:0] sense_bytes;
  logic        out_valid, out_ready, in_valid, in_ready;
  logic [7:0]  out_data, in_data;
  logic        bus_sel_wr, bus_ctl_wr, bus_data_wr, bus_data_rd, dma_en;
  logic [7:0]  bus_ctl_data, bus_wdata, bus_rdata;
  logic        st_sel, st_rdy, st_cmd, st_in, st_irq;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xtb_cmd_seq i_xtb_cmd_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_blk(cmd_blk),
    .use_dma(use_dma), .has_src(has_src), .has_dst(has_dst),
    .tmo_limit(tmo_limit), .busy(busy), .done(done), .result(result),
    .sense_bytes(sense_bytes), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .bus_sel_wr(bus_sel_wr), .bus_ctl_wr(bus_ctl_wr),
    .bus_ctl_data(bus_ctl_data), .bus_data_wr(bus_data_wr),
    .bus_data_rd(bus_data_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .st_sel(st_sel), .st_rdy(st_rdy), .st_cmd(st_cmd), .st_in(st_in),
    .st_irq(st_irq), .dma_en(dma_en)
  );

  // controller model: two scripts (parent command, nested sense)
  logic [1:0] ph [2][16];
  logic [7:0] dd [2][16];
  logic [7:0] csbv [2];
  int plen [2];
  int dev_gap, dev_desel, dma_lat;
  bit dev_mute_sel;
  int cur, ncmd, idx, gap, dmacnt, desel_cnt;
  bit dsel, drdy, dirq, dmabusy, deselecting, prev_sel, order_bad;
  logic [7:0] wlog [32], ctllog [8], inlog [16];
  int wn, cn, rdn, inn, dman;
  logic [1:0] cur_ph;

  assign cur_ph    = (idx < plen[cur]) ? ph[cur][idx] : 2'b00;
  assign st_sel    = dsel;
  assign st_rdy    = drdy;
  assign st_irq    = dirq;
  assign st_cmd    = cur_ph[1];
  assign st_in     = cur_ph[0];
  assign bus_rdata = (cur_ph == 2'b11) ? csbv[cur] : dd[cur][idx];

  always @(posedge clk) begin
    if (!rst_n) begin
      cur <= 0; ncmd <= 0; idx <= 0; gap <= 0; dmacnt <= 0; desel_cnt <= 0;
      dsel <= 0; drdy <= 0; dirq <= 0; dmabusy <= 0; deselecting <= 0;
      prev_sel <= 0; order_bad <= 0; wn <= 0; cn <= 0; rdn <= 0; dman <= 0;
    end else begin
      prev_sel <= bus_sel_wr;
      if (bus_ctl_wr) begin
        if (cn < 8) ctllog[cn] <= bus_ctl_data;
        cn <= cn + 1;
        if (dirq) begin
          dirq <= 0; gap <= dev_gap;
        end else begin
          if (!prev_sel) order_bad <= 1;
          cur <= (ncmd < 2) ? ncmd : 1; ncmd <= ncmd + 1;
          idx <= 0; drdy <= 0; gap <= dev_gap; dsel <= !dev_mute_sel;
        end
      end else if (bus_data_wr) begin
        if (wn < 32) wlog[wn] <= bus_wdata;
        wn <= wn + 1; idx <= idx + 1; drdy <= 0; gap <= dev_gap;
      end else if (bus_data_rd) begin
        rdn <= rdn + 1; drdy <= 0;
        if (cur_ph == 2'b11) begin deselecting <= 1; desel_cnt <= dev_desel; end
        else begin idx <= idx + 1; gap <= dev_gap; end
      end else if (dmabusy) begin
        if (dmacnt == 0) begin dmabusy <= 0; dirq <= 1; idx <= idx + 1; end
        else dmacnt <= dmacnt - 1;
      end else if (dma_en && drdy) begin
        dmabusy <= 1; dmacnt <= dma_lat; drdy <= 0; dman <= dman + 1;
      end else if (deselecting) begin
        if (desel_cnt == 0) begin dsel <= 0; deselecting <= 0; end
        else desel_cnt <= desel_cnt - 1;
      end else if (gap != 0) begin
        gap <= gap - 1;
      end else if (dsel && !drdy && !dirq && idx < plen[cur]) begin
        drdy <= 1;
      end
    end
  end

  // host streams
  logic [7:0] src [8];
  int sidx;
  bit src_on, snk_on;
  assign out_valid = src_on;
  assign out_data  = src[sidx];
  assign in_ready  = snk_on;
  always @(posedge clk) begin
    if (!rst_n) begin sidx <= 0; inn <= 0; end
    else begin
      if (out_valid && out_ready) sidx <= sidx + 1;
      if (in_valid && in_ready) begin
        if (inn < 16) inlog[inn] <= in_data;
        inn <= inn + 1;
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic defaults();
    dev_gap = 1; dev_desel = 2; dma_lat = 3; dev_mute_sel = 0;
    src_on = 1; snk_on = 1; use_dma = 0; has_src = 0; has_dst = 0;
    plen[0] = 0; plen[1] = 0; csbv[0] = 8'h00; csbv[1] = 8'h00;
    tmo_limit = TW'(8);
  endtask

  task automatic add(int s, logic [1:0] p, logic [7:0] d);
    ph[s][plen[s]] = p; dd[s][plen[s]] = d; plen[s]++;
  endtask

  task automatic add_cmd(int s);
    for (int i = 0; i < 6; i++) add(s, 2'b10, 8'h00);
  endtask

  task automatic do_reset();
    rst_n = 0; start = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic launch(logic [47:0] c);
    cmd_blk = c; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(string req);
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    checks++;
    if (!done) begin
      fails++;
      $display("FAIL %s actual=no_done expected=done", req);
    end
  endtask

  localparam logic [47:0] CMD_A = 48'h665544332211;
  localparam logic [47:0] CMD_B = 48'hEEDDCCBBAA99;

  task automatic t_reset_state();
    defaults(); do_reset();
    chk("R1 reset busy", busy, 0);
    chk("R1 reset strobes", {bus_sel_wr, bus_ctl_wr, bus_data_wr, bus_data_rd, dma_en}, 0);
  endtask

  task automatic t_pio_write();
    defaults(); add_cmd(0); add(0, 2'b00, 0); add(0, 2'b00, 0); add(0, 2'b11, 0);
    has_src = 1; src[0] = 8'hA5; src[1] = 8'h3C;
    do_reset(); launch(CMD_A); wait_done("R5 pio write");
    chk("R5 result ok", result, 0);
    chk("R1 mode byte pio", ctllog[0], 8'h00);
    chk("R1 select before mode", order_bad, 0);
    chk("R2 byte count", wn, 8);
    for (int i = 0; i < 6; i++) chk("R2 cmd byte order", wlog[i], CMD_A[8*i +: 8]);
    chk("R3 src byte0", wlog[6], 8'hA5);
    chk("R3 src byte1", wlog[7], 8'h3C);
  endtask

  task automatic t_pio_read();
    defaults(); add_cmd(0); add(0, 2'b01, 8'h11); add(0, 2'b01, 8'h22);
    add(0, 2'b01, 8'h33); add(0, 2'b11, 0);
    has_dst = 1;
    do_reset(); launch(CMD_B); wait_done("R4 pio read");
    chk("R4 result", result, 0);
    chk("R4 in count", inn, 3);
    chk("R4 in bytes", {inlog[0], inlog[1], inlog[2]}, 24'h112233);
  endtask

  task automatic t_no_buffers();
    defaults(); add_cmd(0); add(0, 2'b00, 0); add(0, 2'b00, 0);
    add(0, 2'b01, 8'h77); add(0, 2'b01, 8'h88); add(0, 2'b11, 0);
    src[0] = 8'hFF; src[1] = 8'hFF;
    do_reset(); launch(CMD_A); wait_done("R3 no source");
    chk("R3 zero fill 0", wlog[6], 8'h00);
    chk("R3 zero fill 1", wlog[7], 8'h00);
    chk("R4 discard no in_valid", inn, 0);
    chk("R4 discard still reads", rdn, 3);
    chk("R5 result", result, 0);
  endtask

  task automatic t_backpressure();
    defaults(); add_cmd(0); add(0, 2'b01, 8'h5A); add(0, 2'b11, 0);
    has_dst = 1; snk_on = 0;
    do_reset(); launch(CMD_A);
    repeat (40) @(negedge clk);
    chk("R4 stalled in_valid", in_valid, 1);
    chk("R4 stalled no read", rdn, 0);
    snk_on = 1;
    wait_done("R4 backpressure");
    chk("R4 stall no timeout", result, 0);
    chk("R4 byte after stall", inlog[0], 8'h5A);
  endtask

  task automatic t_dma();
    defaults(); add_cmd(0); add(0, 2'b01, 8'h12); add(0, 2'b00, 0); add(0, 2'b11, 0);
    use_dma = 1; has_dst = 1; has_src = 1;
    do_reset(); launch(CMD_B); wait_done("R8 dma");
    chk("R8 result", result, 0);
    chk("R1 mode byte dma", ctllog[0], 8'h03);
    chk("R8 dma phases", dman, 2);
    chk("R8 ctl writes", cn, 3);
    chk("R8 ack values", {ctllog[1], ctllog[2]}, 16'h0000);
    chk("R8 no pio data reads", rdn, 1);
    chk("R8 no pio data writes", wn, 6);
    chk("R8 no stream beats", inn, 0);
  endtask

  task automatic t_sense();
    defaults(); add_cmd(0); add(0, 2'b11, 0); csbv[0] = 8'hA2;
    add_cmd(1); add(1, 2'b01, 8'hC1); add(1, 2'b01, 8'hC2);
    add(1, 2'b01, 8'hC3); add(1, 2'b01, 8'hC4); add(1, 2'b11, 0);
    use_dma = 1; has_dst = 1;
    do_reset(); launch(CMD_A); wait_done("R7 sense");
    chk("R7 result err", result, 2);
    chk("R7 sense bytes", sense_bytes, 32'hC4C3C2C1);
    chk("R7 sense mode pio", ctllog[1], 8'h00);
    chk("R7 sense opcode", wlog[6], 8'h03);
    chk("R7 sense lun", wlog[7], 8'hA0);
    chk("R7 sense tail", {wlog[8], wlog[9], wlog[10], wlog[11]}, 32'h0);
    chk("R7 sense not streamed", inn, 0);
  endtask

  task automatic t_timeouts();
    defaults(); dev_mute_sel = 1; add_cmd(0); add(0, 2'b11, 0);
    do_reset(); launch(CMD_A); wait_done("R6 select timeout");
    chk("R6 select timeout result", result, 1);
    @(negedge clk);
    chk("R6 idle after timeout", busy, 0);

    defaults(); dev_gap = 7; add_cmd(0); add(0, 2'b11, 0);
    do_reset(); launch(CMD_A); wait_done("R6 ready timeout");
    chk("R6 ready gap at limit", result, 1);
    chk("R6 one byte before timeout", wn, 1);

    defaults(); dev_desel = 20; add_cmd(0); add(0, 2'b11, 0); csbv[0] = 8'h02;
    do_reset(); launch(CMD_A); wait_done("R6 deselect timeout");
    chk("R6 deselect timeout", result, 1);
    chk("R6 no sense after timeout", cn, 1);
  endtask

  task automatic t_reload();
    defaults(); dev_gap = 6; add_cmd(0); add(0, 2'b00, 0); add(0, 2'b11, 0);
    do_reset(); launch(CMD_B); wait_done("R10 long command");
    chk("R10 gap below limit ok", result, 0);
    chk("R10 all bytes", wn, 7);
  endtask

  task automatic t_busy_start();
    defaults(); dev_gap = 6; add_cmd(0); add(0, 2'b11, 0);
    do_reset(); launch(CMD_A);
    repeat (10) @(negedge clk);
    launch(CMD_B);
    wait_done("R9 busy start");
    chk("R9 one mode write", cn, 1);
    chk("R9 first cmd kept", wlog[0], CMD_A[7:0]);
    chk("R9 last cmd kept", wlog[5], CMD_A[47:40]);
  endtask

  initial begin
    t_reset_state();
    t_pio_write();
    t_pio_read();
    t_no_buffers();
    t_backpressure();
    t_dma();
    t_sense();
    t_timeouts();
    t_reload();
    t_busy_start();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule